// File: doc/BRIEF.md
# Exception Stack Frame Sequencer

This block writes the stack frame that a 68000-family processor leaves in memory when it takes an exception. It also reads such a frame back when the processor returns from one. On an entry request it captures four things: the status word in force before the exception, the program counter, a fault address and the vector number. It also takes the frame format chosen by the exception class, for example format 0 for a trap or format 2 for a divide fault. From these it derives the supervisor status word, pushes the frame word by word and long by long through a single request/acknowledge memory port, and then fetches the handler address from the vector table.

A hardware interrupt that arrives while the master bit is set causes two frames to be pushed. The first is a normal format 0 frame on the current stack. The second is a format 1 throwaway frame on the alternate (interrupt) stack. On an unwind request the block reads the status word, the return address and the format word from the stack. A format 1 frame makes it repeat the unwind one frame higher. Any other format makes it step the stack pointer past the frame body and finish.

The block keeps one memory access outstanding at a time. It raises `busy_o` from acceptance to completion and gives a single `done_o` pulse at the end.

Top module: `exc_frame_seq`

## Requirements
- R1: On entry, the resulting status word has bit 13 (supervisor) set and bit 15 (trace) cleared, and all other bits are copied from `old_sr_i`. For a hardware interrupt only, bits 10:8 are replaced by `irq_lvl_i`.
- R2: With `ALIGN_SP`=1, bit 0 of every stack pointer taken for pushing (`sp_i` and `alt_sp_i`) is cleared before the first push on that stack.
- R3: Each push first decrements the stack pointer by the access size (4 for a long, 2 for a word) and then writes at the new value. The push order is fixed by format:
  - format 4 pushes long PC, then long fault address;
  - formats 2 and 3 push one long fault address;
  - every format then pushes the format word (word), the return PC (long) and the status word (word).
- R4: The format word is {format[3:0], 2'b00, vector[7:0], 2'b00}, that is format in bits 15:12 and vector times four in the low bits. Word writes carry their data in `mem_wdata_o[15:0]`.
- R5: When `hw_irq_i`=1 and bit 12 (master) of `old_sr_i` is set:
  - a format 0 frame holding `old_sr_i` is pushed on the `sp_i` stack, and `master_sp_o` reports that stack's final pointer;
  - a format 1 frame holding the R1 status word (bit 12 still set) is then pushed on the `alt_sp_i` stack;
  - the final `sr_o` has bit 12 cleared.
- R6: After the last push, a long read at `vbr_i + 4*vector_i` fetches the handler address, which appears on `pc_o`. `sp_o` then holds the final stack pointer.
- R7: An unwind reads a word at SP (status, onto `sr_o`), a long at SP+2 (return PC, onto `pc_o`) and a word at SP+6 (format in bits 15:12). For format 1 the unwind repeats from SP+8.
- R8: After a non-1 format word, `sp_o` = SP + 8 + skip. The skip is 0 for format 0, 4 for formats 2 and 3, 8 for format 4, 52 for format 7, and 0 for any other code.
- R9: `busy_o` is high from the cycle after acceptance until `done_o`. `done_o` is a one-cycle pulse, given after the last memory access.
- R10: `enter_i` and `unwind_i` have no effect while `busy_o` is high. Entry has priority when both are raised in idle.
- R11: A memory request keeps address, data, direction and size stable until `mem_ack_i`, and each acknowledge advances exactly one access.
- R12: After reset, `busy_o`, `done_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enter_i | input | 1 | Start an exception entry (idle only) |
| unwind_i | input | 1 | Start a return unwind (idle only) |
| hw_irq_i | input | 1 | Entry is a hardware interrupt |
| irq_lvl_i | input | 3 | Pending interrupt level |
| old_sr_i | input | 16 | Status word before the exception |
| pc_i | input | AW | PC pushed as return and format 4 address |
| fault_addr_i | input | AW | Address for format 2/3/4 frames |
| vector_i | input | 8 | Vector number |
| format_i | input | 4 | Frame format for this exception class |
| sp_i | input | AW | Current stack pointer |
| alt_sp_i | input | AW | Interrupt stack pointer for the throwaway case |
| vbr_i | input | AW | Vector table base |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write |
| mem_long_o | output | 1 | 1 = long, 0 = word |
| mem_addr_o | output | AW | Byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access complete |
| mem_rdata_i | input | 32 | Read data (words in 15:0) |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | Sequence finished pulse |
| sp_o | output | AW | Resulting stack pointer |
| master_sp_o | output | AW | First-stack pointer after a throwaway entry |
| sr_o | output | 16 | Resulting status word |
| pc_o | output | AW | Handler address or return PC |

## Verification
The assertions assume that `mem_ack_i` is only raised while `mem_req_o` is high and lasts one cycle. They also assume that read data is valid in the acknowledge cycle. The bench's responder raises the acknowledge for exactly one cycle, after a latency of zero to two cycles that rotates between accesses, and lowers it at once. It only does so while a request is pending. Start pulses are driven for a single cycle at idle. The only start pulses raised while busy are the deliberate ones that exercise R10.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int SR_T      = 15;
  localparam int SR_S      = 13;
  localparam int SR_M      = 12;
  localparam int SR_IPL_LO = 8;
  localparam int IPL_W     = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH, ST_VEC, ST_POP_SR, ST_POP_PC, ST_POP_FMT
  } seq_state_e;

  typedef enum logic [2:0] {
    SLOT_PC, SLOT_FAULT, SLOT_FMTW, SLOT_RET, SLOT_SR
  } slot_e;
endpackage

// File: rtl/exc_entry_sr.sv
module exc_entry_sr
  import exc_seq_pkg::*;
(
  input  logic [15:0]      old_sr_i,
  input  logic             hw_irq_i,
  input  logic [IPL_W-1:0] irq_lvl_i,
  output logic [15:0]      new_sr_o,
  output logic             nest_o
);
  always_comb begin
    new_sr_o       = old_sr_i;
    new_sr_o[SR_S] = 1'b1;
    new_sr_o[SR_T] = 1'b0;
    if (hw_irq_i) new_sr_o[SR_IPL_LO +: IPL_W] = irq_lvl_i;
    nest_o = hw_irq_i & old_sr_i[SR_M];
  end
endmodule

// File: rtl/exc_push_plan.sv
module exc_push_plan
  import exc_seq_pkg::*;
(
  input  logic [3:0] fmt_i,
  input  logic [2:0] step_i,
  output slot_e      slot_o,
  output logic       long_o,
  output logic       last_o
);
  logic [2:0] extra;

  always_comb begin
    case (fmt_i)
      4'd4:       extra = 3'd2;
      4'd2, 4'd3: extra = 3'd1;
      default:    extra = 3'd0;
    endcase
    if (step_i < extra) begin
      slot_o = (fmt_i == 4'd4 && step_i == 3'd0) ? SLOT_PC : SLOT_FAULT;
    end else begin
      case (step_i - extra)
        3'd0:    slot_o = SLOT_FMTW;
        3'd1:    slot_o = SLOT_RET;
        default: slot_o = SLOT_SR;
      endcase
    end
    long_o = (slot_o == SLOT_PC) || (slot_o == SLOT_FAULT) || (slot_o == SLOT_RET);
    last_o = (step_i == extra + 3'd2);
  end
endmodule

// File: rtl/exc_unwind_skip.sv
module exc_unwind_skip (
  input  logic [3:0] fmt_i,
  output logic [7:0] skip_o
);
  always_comb begin
    case (fmt_i)
      4'd2, 4'd3: skip_o = 8'd4;
      4'd4:       skip_o = 8'd8;
      4'd7:       skip_o = 8'd52;
      default:    skip_o = 8'd0;
    endcase
  end
endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
  import exc_seq_pkg::*;
#(
  parameter int AW       = 32,
  parameter int VEC_W    = 8,
  parameter bit ALIGN_SP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enter_i,
  input  logic             unwind_i,
  input  logic             hw_irq_i,
  input  logic [IPL_W-1:0] irq_lvl_i,
  input  logic [15:0]      old_sr_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [AW-1:0]    fault_addr_i,
  input  logic [VEC_W-1:0] vector_i,
  input  logic [3:0]       format_i,
  input  logic [AW-1:0]    sp_i,
  input  logic [AW-1:0]    alt_sp_i,
  input  logic [AW-1:0]    vbr_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic             mem_long_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [31:0]      mem_rdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [AW-1:0]    sp_o,
  output logic [AW-1:0]    master_sp_o,
  output logic [15:0]      sr_o,
  output logic [AW-1:0]    pc_o
);
  localparam int FPAD = 12 - VEC_W - 2;

  seq_state_e       state_q, state_d;
  logic [2:0]       step_q, step_d;
  logic [AW-1:0]    sp_q, sp_d, msp_q, msp_d, pc_q, pc_d;
  logic [AW-1:0]    fault_q, fault_d, alt_q, alt_d, vbr_q, vbr_d;
  logic [15:0]      sr_q, sr_d, fsr_q, fsr_d;
  logic [3:0]       fmt_q, fmt_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             nest_q, nest_d, second_q, second_d, entry_q, entry_d, done_q, done_d;

  logic [15:0]   ent_sr;
  logic          ent_nest;
  slot_e         slot;
  logic          slot_long, slot_last;
  logic [7:0]    skip;
  logic [AW-1:0] push_addr;

  exc_entry_sr u_sr (
    .old_sr_i(old_sr_i), .hw_irq_i(hw_irq_i), .irq_lvl_i(irq_lvl_i),
    .new_sr_o(ent_sr), .nest_o(ent_nest)
  );

  exc_push_plan u_plan (
    .fmt_i(fmt_q), .step_i(step_q), .slot_o(slot), .long_o(slot_long), .last_o(slot_last)
  );

  exc_unwind_skip u_skip (.fmt_i(mem_rdata_i[15:12]), .skip_o(skip));

  function automatic logic [AW-1:0] align_sp(input logic [AW-1:0] v);
    return ALIGN_SP ? {v[AW-1:1], 1'b0} : v;
  endfunction

  assign push_addr = sp_q - (slot_long ? AW'(4) : AW'(2));

  // Memory port: driven only from registered state, so it is held until ack.
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_long_o  = 1'b0;
    mem_addr_o  = sp_q;
    mem_wdata_o = 32'h0;
    case (state_q)
      ST_PUSH: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_long_o = slot_long;
        mem_addr_o = push_addr;
        case (slot)
          SLOT_PC, SLOT_RET: mem_wdata_o = 32'(pc_q);
          SLOT_FAULT:        mem_wdata_o = 32'(fault_q);
          SLOT_FMTW:         mem_wdata_o = {16'h0, fmt_q, {FPAD{1'b0}}, vec_q, 2'b00};
          default:           mem_wdata_o = {16'h0, fsr_q};
        endcase
      end
      ST_VEC: begin
        mem_req_o  = 1'b1;
        mem_long_o = 1'b1;
        mem_addr_o = vbr_q + {{(AW-VEC_W-2){1'b0}}, vec_q, 2'b00};
      end
      ST_POP_SR:  mem_req_o = 1'b1;
      ST_POP_PC:  begin mem_req_o = 1'b1; mem_long_o = 1'b1; mem_addr_o = sp_q + AW'(2); end
      ST_POP_FMT: begin mem_req_o = 1'b1; mem_addr_o = sp_q + AW'(6); end
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q; step_d = step_q; sp_d = sp_q; msp_d = msp_q; pc_d = pc_q;
    fault_d = fault_q; alt_d = alt_q; vbr_d = vbr_q; sr_d = sr_q; fsr_d = fsr_q;
    fmt_d = fmt_q; vec_d = vec_q; nest_d = nest_q; second_d = second_q;
    entry_d = entry_q; done_d = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (enter_i) begin
          state_d  = ST_PUSH;
          step_d   = 3'd0;
          sp_d     = align_sp(sp_i);
          pc_d     = pc_i;
          fault_d  = fault_addr_i;
          alt_d    = alt_sp_i;
          vbr_d    = vbr_i;
          vec_d    = vector_i;
          fsr_d    = old_sr_i;
          nest_d   = ent_nest;
          fmt_d    = ent_nest ? 4'd0 : format_i;
          sr_d     = ent_nest ? (ent_sr & ~(16'h1 << SR_M)) : ent_sr;
          second_d = 1'b0;
          entry_d  = 1'b1;
        end else if (unwind_i) begin
          state_d = ST_POP_SR;
          sp_d    = sp_i;
          entry_d = 1'b0;
        end
      end
      ST_PUSH: if (mem_ack_i) begin
        sp_d   = push_addr;
        step_d = step_q + 3'd1;
        if (slot_last) begin
          if (!second_q) msp_d = push_addr;
          if (nest_q) begin
            sp_d     = align_sp(alt_q);
            step_d   = 3'd0;
            fmt_d    = 4'd1;
            fsr_d    = sr_q | (16'h1 << SR_M);
            nest_d   = 1'b0;
            second_d = 1'b1;
          end else begin
            state_d = ST_VEC;
          end
        end
      end
      ST_VEC: if (mem_ack_i) begin
        pc_d    = mem_rdata_i[AW-1:0];
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      ST_POP_SR: if (mem_ack_i) begin
        sr_d    = mem_rdata_i[15:0];
        state_d = ST_POP_PC;
      end
      ST_POP_PC: if (mem_ack_i) begin
        pc_d    = mem_rdata_i[AW-1:0];
        state_d = ST_POP_FMT;
      end
      ST_POP_FMT: if (mem_ack_i) begin
        if (mem_rdata_i[15:12] == 4'd1) begin
          sp_d    = sp_q + AW'(8);
          state_d = ST_POP_SR;
        end else begin
          sp_d    = sp_q + AW'(8) + AW'(skip);
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; step_q <= '0; sp_q <= '0; msp_q <= '0; pc_q <= '0;
      fault_q <= '0; alt_q <= '0; vbr_q <= '0; sr_q <= '0; fsr_q <= '0;
      fmt_q <= '0; vec_q <= '0; nest_q <= 1'b0; second_q <= 1'b0;
      entry_q <= 1'b0; done_q <= 1'b0;
    end else begin
      state_q <= state_d; step_q <= step_d; sp_q <= sp_d; msp_q <= msp_d; pc_q <= pc_d;
      fault_q <= fault_d; alt_q <= alt_d; vbr_q <= vbr_d; sr_q <= sr_d; fsr_q <= fsr_d;
      fmt_q <= fmt_d; vec_q <= vec_d; nest_q <= nest_d; second_q <= second_d;
      entry_q <= entry_d; done_q <= done_d;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign sp_o        = sp_q;
  assign master_sp_o = msp_q;
  assign sr_o        = sr_q;
  assign pc_o        = pc_q;

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o)
      && $stable(mem_we_o) && $stable(mem_long_o));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !mem_req_o);
  p_entry_sr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && entry_q |-> sr_o[SR_S] && !sr_o[SR_T]);
  p_even_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ALIGN_SP && mem_req_o && mem_we_o |-> !mem_addr_o[0]);
  p_busy_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !(mem_req_o && mem_ack_i) |=> busy_o && $stable(sp_o));
endmodule

// File: tb/sim_exc_frame_seq.sv
module sim_exc_frame_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  typedef struct {
    bit          we;
    bit          lng;
    logic [31:0] addr;
    logic [31:0] data;
    string       req;
  } txn_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enter_i = 0, unwind_i = 0, hw_irq_i = 0;
  logic [2:0] irq_lvl_i = 0;
  logic [15:0] old_sr_i = 0;
  logic [31:0] pc_i = 0, fault_addr_i = 0, sp_i = 0, alt_sp_i = 0, vbr_i = 0;
  logic [7:0] vector_i = 0;
  logic [3:0] format_i = 0;
  logic mem_req_o, mem_we_o, mem_long_o, mem_ack_i = 0;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i = 0;
  logic busy_o, done_o;
  logic [31:0] sp_o, master_sp_o, pc_o;
  logic [15:0] sr_o;

  int nchk = 0, nfail = 0, cyc = 0, wait_cnt = 0, lat = 0;
  txn_t expq[$];
  logic [7:0] mem [int unsigned];

  exc_frame_seq u0 (
    .clk(clk), .rst_n(rst_n), .enter_i(enter_i), .unwind_i(unwind_i), .hw_irq_i(hw_irq_i),
    .irq_lvl_i(irq_lvl_i), .old_sr_i(old_sr_i), .pc_i(pc_i), .fault_addr_i(fault_addr_i),
    .vector_i(vector_i), .format_i(format_i), .sp_i(sp_i), .alt_sp_i(alt_sp_i), .vbr_i(vbr_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_long_o(mem_long_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
    .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o), .sp_o(sp_o),
    .master_sp_o(master_sp_o), .sr_o(sr_o), .pc_o(pc_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rdb(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  task automatic wr16(input logic [31:0] a, input logic [15:0] d);
    mem[a] = d[15:8]; mem[a+1] = d[7:0];
  endtask

  task automatic wr32(input logic [31:0] a, input logic [31:0] d);
    wr16(a, d[31:16]); wr16(a + 2, d[15:0]);
  endtask

  task automatic expect_t(input bit we, input bit lng, input logic [31:0] a,
                          input logic [31:0] d, input string req);
    txn_t t;
    t.we = we; t.lng = lng; t.addr = a; t.data = d; t.req = req;
    expq.push_back(t);
  endtask

  // Memory responder and per-cycle comparison against the expected access queue.
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack_i = 0; wait_cnt = 0;
    end else begin
      if (mem_req_o && !busy_o) chk(0, "R12 request while idle", 1, 0);
      if (mem_ack_i) mem_ack_i = 0;
      else if (mem_req_o) begin
        if (wait_cnt < lat) wait_cnt++;
        else begin
          txn_t e;
          logic [31:0] wd;
          wait_cnt = 0; lat = (lat + 1) % 3;
          wd = mem_long_o ? mem_wdata_o : {16'h0, mem_wdata_o[15:0]};
          if (expq.size() == 0) chk(0, "R11 unexpected access", mem_addr_o, 0);
          else begin
            e = expq.pop_front();
            chk(mem_we_o == e.we && mem_long_o == e.lng && mem_addr_o == e.addr,
                {e.req, " access kind/address"}, {mem_we_o, mem_long_o, mem_addr_o[29:0]},
                {e.we, e.lng, e.addr[29:0]});
            if (e.we) chk(wd == e.data, {e.req, " write data"}, wd, e.data);
          end
          if (mem_we_o) begin
            if (mem_long_o) wr32(mem_addr_o, mem_wdata_o); else wr16(mem_addr_o, mem_wdata_o[15:0]);
          end else if (mem_long_o)
            mem_rdata_i = {rdb(mem_addr_o), rdb(mem_addr_o+1), rdb(mem_addr_o+2), rdb(mem_addr_o+3)};
          else
            mem_rdata_i = {16'h0, rdb(mem_addr_o), rdb(mem_addr_o+1)};
          mem_ack_i = 1;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++; nchk++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  // Model of one pushed frame (R3, R4).
  task automatic model_frame(inout logic [31:0] s, input logic [3:0] f, input logic [15:0] sr,
                             input logic [31:0] pc, input logic [31:0] fa, input logic [7:0] v);
    if (f == 4) begin
      s -= 4; expect_t(1, 1, s, pc, "R3 fmt4 pc");
      s -= 4; expect_t(1, 1, s, fa, "R3 fmt4 fault");
    end else if (f == 2 || f == 3) begin
      s -= 4; expect_t(1, 1, s, fa, "R3 fault long");
    end
    s -= 2; expect_t(1, 0, s, {16'h0, f, 2'b00, v, 2'b00}, "R4 format word");
    s -= 4; expect_t(1, 1, s, pc, "R3 return pc");
    s -= 2; expect_t(1, 0, s, {16'h0, sr}, "R3 status word");
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done_o && n < 5000) begin @(negedge clk); n++; end
    chk(done_o, {req, " R9 done seen"}, done_o, 1);
  endtask

  task automatic run_entry(input bit hw, input logic [2:0] lvl, input logic [15:0] osr,
                           input logic [31:0] pc, input logic [31:0] fa, input logic [7:0] v,
                           input logic [3:0] f, input logic [31:0] sp, input logic [31:0] alt,
                           input logic [31:0] vbr, input logic [31:0] hnd, input bit poke);
    logic [15:0] nsr, fsr;
    logic [31:0] s, msp;
    nsr = (osr | 16'h2000) & ~16'h8000;
    if (hw) nsr = (nsr & ~16'h0700) | ({13'h0, lvl} << 8);
    s = sp & ~32'h1;
    if (hw && osr[12]) begin
      model_frame(s, 0, osr, pc, fa, v);
      msp = s;
      s = alt & ~32'h1;
      model_frame(s, 1, nsr, pc, fa, v);
      fsr = nsr & ~16'h1000;
    end else begin
      model_frame(s, f, osr, pc, fa, v);
      msp = s;
      fsr = nsr;
    end
    wr32(vbr + {22'h0, v, 2'b00}, hnd);
    expect_t(0, 1, vbr + {22'h0, v, 2'b00}, 0, "R6 vector fetch");
    @(negedge clk);
    hw_irq_i = hw; irq_lvl_i = lvl; old_sr_i = osr; pc_i = pc; fault_addr_i = fa;
    vector_i = v; format_i = f; sp_i = sp; alt_sp_i = alt; vbr_i = vbr; enter_i = 1;
    @(negedge clk);
    enter_i = 0;
    chk(busy_o, "R9 busy after entry", busy_o, 1);
    if (poke) begin
      // R10: start pulses while busy must be ignored
      @(negedge clk); @(negedge clk);
      sp_i = 32'hDEAD0000; alt_sp_i = 32'hBEEF0000; enter_i = 1; unwind_i = 1;
      @(negedge clk);
      enter_i = 0; unwind_i = 0;
    end
    wait_done("entry");
    chk(sr_o == fsr, "R1 entry status word", sr_o, fsr);
    chk(sp_o == s, "R6 final stack pointer", sp_o, s);
    chk(pc_o == hnd, "R6 handler address", pc_o, hnd);
    if (hw && osr[12]) chk(master_sp_o == msp, "R5 master stack pointer", master_sp_o, msp);
    @(negedge clk);
    chk(!done_o && !busy_o, "R9 done single pulse", {done_o, busy_o}, 0);
    chk(expq.size() == 0, "R10 no extra accesses", expq.size(), 0);
  endtask

  task automatic run_unwind(input logic [31:0] sp, input logic [15:0] esr,
                            input logic [31:0] epc, input logic [31:0] esp, input string req);
    @(negedge clk);
    sp_i = sp; unwind_i = 1;
    @(negedge clk);
    unwind_i = 0;
    wait_done(req);
    chk(sr_o == esr, {req, " status word"}, sr_o, esr);
    chk(pc_o == epc, {req, " return pc"}, pc_o, epc);
    chk(sp_o == esp, {req, " stack pointer"}, sp_o, esp);
    @(negedge clk);
    chk(expq.size() == 0, {req, " access count"}, expq.size(), 0);
  endtask

  task automatic put_frame(input logic [31:0] a, input logic [15:0] sr, input logic [31:0] pc,
                           input logic [3:0] f);
    wr16(a, sr); wr32(a + 2, pc); wr16(a + 6, {f, 12'h018});
    expect_t(0, 0, a, 0, "R7 read status");
    expect_t(0, 1, a + 2, 0, "R7 read pc");
    expect_t(0, 0, a + 6, 0, "R7 read format");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !mem_req_o, "R12 reset outputs", {busy_o, done_o, mem_req_o}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy_o && !done_o && !mem_req_o, "R12 after release", {busy_o, done_o, mem_req_o}, 0);

    // format 0 trap, trace bit cleared (R1, R3, R4, R6)
    run_entry(0, 0, 16'h8015, 32'h0000_1000, 0, 8'd32, 4'd0, 32'h8000, 0, 32'h0, 32'h0000_4000, 0);
    // format 2 with odd SP (R2, R3)
    run_entry(0, 0, 16'h0000, 32'h0000_2000, 32'h0000_1234, 8'd5, 4'd2, 32'h7001, 0, 32'h100, 32'h0000_5000, 0);
    // format 4 (R3)
    run_entry(0, 0, 16'h2004, 32'h0000_3000, 32'hABCD_0000, 8'd11, 4'd4, 32'h6000, 0, 32'h200, 32'h0000_6000, 0);
    // format 3 (R3)
    run_entry(0, 0, 16'h0010, 32'h0000_3100, 32'h0000_0777, 8'd7, 4'd3, 32'h6100, 0, 32'h200, 32'h0000_6100, 0);
    // hardware interrupt, master clear: mask loaded (R1)
    run_entry(1, 3'd5, 16'h2300, 32'h0000_4000, 0, 8'd29, 4'd0, 32'h5800, 0, 32'h0, 32'h0000_7000, 0);
    // hardware interrupt in master mode: throwaway frame (R5, R2)
    run_entry(1, 3'd6, 16'h3000, 32'h0000_4444, 0, 8'd30, 4'd0, 32'h5001, 32'h9003, 32'h0, 32'h0000_7100, 0);
    // ignored start pulses while busy (R10, R11)
    run_entry(0, 0, 16'h0001, 32'h0000_1500, 0, 8'd40, 4'd0, 32'hA000, 0, 32'h0, 32'h0000_4500, 1);

    // unwinds (R7, R8)
    put_frame(32'h3000, 16'h0004, 32'h1111_2222, 4'd0);
    run_unwind(32'h3000, 16'h0004, 32'h1111_2222, 32'h3008, "R8 fmt0");
    put_frame(32'h3000, 16'h0008, 32'h1111_3333, 4'd2);
    run_unwind(32'h3000, 16'h0008, 32'h1111_3333, 32'h300C, "R8 fmt2");
    put_frame(32'h3000, 16'h0009, 32'h1111_4444, 4'd4);
    run_unwind(32'h3000, 16'h0009, 32'h1111_4444, 32'h3010, "R8 fmt4");
    put_frame(32'h3000, 16'h000A, 32'h1111_5555, 4'd7);
    run_unwind(32'h3000, 16'h000A, 32'h1111_5555, 32'h303C, "R8 fmt7");
    put_frame(32'h3000, 16'h000B, 32'h1111_6666, 4'd9);
    run_unwind(32'h3000, 16'h000B, 32'h1111_6666, 32'h3008, "R8 other fmt");
    put_frame(32'h3100, 16'h3000, 32'h2222_0000, 4'd1);
    put_frame(32'h3108, 16'h0010, 32'h2222_1111, 4'd0);
    run_unwind(32'h3100, 16'h0010, 32'h2222_1111, 32'h3110, "R7 fmt1 restart");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule